// File: doc/BRIEF.md
# Synthesizer Configuration Register with Parallel and Serial Load

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback divider value, a 2-bit post-divider code and a 3-bit test-select code. Two independent routes write it. A parallel route takes the divider value and the post-divider code straight from pins when its strobe rises. A three-wire serial route shifts a 14-bit word in, one bit per rising serial-clock edge, and moves the whole word into the settings when its strobe falls. The test-select code can only be written through the serial word.

Every strobe, the serial clock and the serial data bit go through two-flop synchronizers into the system clock domain before their edges are detected. A two-state arbiter decides which route may write. It starts in `ST_PBLOCK`, where the parallel strobe is low. In this state every serial commit is dropped. A detected parallel rise writes the pin values and takes the transition `T_PAR_CAPTURE` to `ST_OPEN`. In `ST_OPEN` a detected serial fall writes the shifted word (`T_SER_COMMIT`, no change of state). A detected parallel fall takes the transition `T_PAR_DROP` back to `ST_PBLOCK`, and any serial fall seen in that same cycle is dropped. The block decodes the post-divider code into a one-hot ratio. It pulses an update flag for one cycle whenever the stored settings take a new value.

Top module: `synth_cfg_reg`

## Requirements
- R1: While reset is applied and just after it, the divider value reads all ones (0x1FF), the post-divider code reads 00, the test code reads 000, the ratio output reads 4'b0001, and the update flag is low. The serial shift register clears to zero.
- R2: A rising edge on the parallel strobe loads the parallel divider pins into the divider value and the parallel code pins into the post-divider code.
- R3: Each rising serial-clock edge shifts the serial data bit in at bit 0, with the first bit sent ending at bit 13 (MSB first). A falling serial strobe loads bits [13:11] into the test code, bits [10:9] into the post-divider code and bits [8:0] into the divider value.
- R4: A serial commit with no serial-clock edge since reset writes an all-zero word: divider 0, post-divider code 00, test code 000.
- R5: A falling serial strobe has no effect on the stored settings while the parallel strobe is low.
- R6: When a parallel rise and a serial fall are detected in the same cycle, the parallel pins are written and the test code keeps its old value.
- R7: A parallel load never changes the test code.
- R8: The ratio output is one-hot: code 00 gives 4'b0001 (divide by 1), 01 gives 4'b0010 (by 2), 10 gives 4'b0100 (by 4) and 11 gives 4'b1000 (by 8).
- R9: The update flag is high for exactly one cycle, in the first cycle the new settings show at the outputs. A load that writes values equal to the stored ones raises no pulse.
- R10: A strobe edge driven on a pin just after a clock edge shows on the outputs after the third following clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_strobe | input | 1 | Parallel load strobe; its rising edge captures the pins |
| par_m | input | 9 | Parallel divider value pins |
| par_n | input | 2 | Parallel post-divider code pins |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_data | input | 1 | Serial data bit, MSB first |
| ser_strobe | input | 1 | Serial load strobe; its falling edge commits the word |
| cfg_m | output | 9 | Stored feedback divider value |
| cfg_n | output | 2 | Stored post-divider code |
| cfg_t | output | 3 | Stored test-select code |
| div_ratio_oh | output | 4 | One-hot post-divide ratio (1, 2, 4, 8) |
| cfg_update | output | 1 | One-cycle pulse when the stored settings change |

## Verification
The hardest case to reach is a parallel rise and a serial fall landing in the same system-clock cycle. From the pins this only happens when both strobes change between the same two clock edges, so that they move through synchronizers of equal depth in lockstep. The bench holds the parallel strobe low and shifts a full serial word. It raises the serial strobe, then at one falling clock edge raises the parallel strobe and drops the serial strobe together. A second case drops a serial commit by pulsing the serial strobe while the parallel strobe is low. The outputs are then checked unchanged before the parallel strobe is released.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    parameter int CFG_M_W = 9;
    parameter int CFG_N_W = 2;
    parameter int CFG_T_W = 3;
    parameter int CFG_SYNC_STAGES = 2;

    typedef enum logic [0:0] {
        ST_PBLOCK = 1'b0,
        ST_OPEN   = 1'b1
    } arb_state_e;

    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_PAR  = 2'd1,
        CM_SER  = 2'd2
    } commit_e;

endpackage

// File: rtl/cfg_sync_bank.sv
module cfg_sync_bank #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pin_i,
    output logic [LANES-1:0] lvl_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] chain_q;

        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i[l];
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i[l]};
            end
        end

        assign lvl_o[l] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lvl_i,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    logic [LANES-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R10: a detected edge lasts exactly one cycle
        a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[l] |=> !rise_o[l]);
        a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[l] |=> !fall_o[l]);
    end

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int SR_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [SR_W-1:0] word_o
);

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[SR_W-2:0], bit_in};
    end

    assign word_o = sr_q;

    // R3: the word moves only on a detected serial-clock rise
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
    // R3: the bit just taken sits at the bottom
    a_r3_bit_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[0] == $past(bit_in));

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
    import cfg_pkg::*;
#(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3,
    localparam int SR_W = M_W + N_W + T_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            p_rise,
    input  logic            p_fall,
    input  logic            s_fall,
    input  logic [M_W-1:0]  pin_m,
    input  logic [N_W-1:0]  pin_n,
    input  logic [SR_W-1:0] sr_word,
    output logic [M_W-1:0]  m_o,
    output logic [N_W-1:0]  n_o,
    output logic [T_W-1:0]  t_o,
    output logic            upd_o
);

    arb_state_e state_q, state_d;
    commit_e    sel;

    logic [M_W-1:0] m_q, m_d;
    logic [N_W-1:0] n_q, n_d;
    logic [T_W-1:0] t_q, t_d;
    logic           upd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PBLOCK;
        else        state_q <= state_d;
    end

    // transitions and commit selection
    always_comb begin
        state_d = state_q;
        sel     = CM_NONE;
        unique case (state_q)
            ST_PBLOCK: begin
                if (p_rise) begin
                    sel     = CM_PAR;      // T_PAR_CAPTURE
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (p_fall) begin
                    state_d = ST_PBLOCK;   // T_PAR_DROP
                end else if (s_fall) begin
                    sel     = CM_SER;      // T_SER_COMMIT
                end
            end
        endcase
    end

    // next settings
    always_comb begin
        m_d = m_q;
        n_d = n_q;
        t_d = t_q;
        unique case (sel)
            CM_PAR: begin
                m_d = pin_m;
                n_d = pin_n;
            end
            CM_SER: begin
                t_d = sr_word[SR_W-1 -: T_W];
                n_d = sr_word[M_W +: N_W];
                m_d = sr_word[M_W-1:0];
            end
            default: ;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q   <= '1;
            n_q   <= '0;
            t_q   <= '0;
            upd_q <= 1'b0;
        end else begin
            m_q   <= m_d;
            n_q   <= n_d;
            t_q   <= t_d;
            upd_q <= (sel != CM_NONE) && ({m_d, n_d, t_d} != {m_q, n_q, t_q});
        end
    end

    assign m_o   = m_q;
    assign n_o   = n_q;
    assign t_o   = t_q;
    assign upd_o = upd_q;

    // R5: serial fall while the parallel strobe is low leaves settings alone
    a_r5_blocked_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PBLOCK && s_fall && !p_rise) |=> $stable({m_q, n_q, t_q}));
    // R6: coincident parallel rise and serial fall, pins win
    a_r6_parallel_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rise && s_fall) |=> (m_q == $past(pin_m)) && (n_q == $past(pin_n)));
    // R7: parallel load keeps the test code
    a_r7_t_kept: assert property (@(posedge clk) disable iff (!rst_n)
        p_rise |=> $stable(t_q));
    // R9: pulse only with a real change
    a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> ({m_q, n_q, t_q} != $past({m_q, n_q, t_q})));

endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
    import cfg_pkg::*;
#(
    parameter int M_W         = CFG_M_W,
    parameter int N_W         = CFG_N_W,
    parameter int T_W         = CFG_T_W,
    parameter int SYNC_STAGES = CFG_SYNC_STAGES,
    localparam int SR_W       = M_W + N_W + T_W,
    localparam int RATIO_W    = 1 << N_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_strobe,
    input  logic [M_W-1:0]     par_m,
    input  logic [N_W-1:0]     par_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_strobe,
    output logic [M_W-1:0]     cfg_m,
    output logic [N_W-1:0]     cfg_n,
    output logic [T_W-1:0]     cfg_t,
    output logic [RATIO_W-1:0] div_ratio_oh,
    output logic               cfg_update
);

    localparam int L_PAR  = 0;
    localparam int L_SCLK = 1;
    localparam int L_SLD  = 2;
    localparam int L_DATA = 3;

    logic [3:0] sync_lvl;
    logic [2:0] rise, fall;
    logic [SR_W-1:0] sr_word;

    cfg_sync_bank #(.LANES(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ser_data, ser_strobe, ser_clk, par_strobe}),
        .lvl_o (sync_lvl)
    );

    cfg_edge_det #(.LANES(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lvl[2:0]),
        .rise_o (rise),
        .fall_o (fall)
    );

    cfg_shift_reg #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise[L_SCLK]),
        .bit_in   (sync_lvl[L_DATA]),
        .word_o   (sr_word)
    );

    cfg_commit_ctrl #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_rise  (rise[L_PAR]),
        .p_fall  (fall[L_PAR]),
        .s_fall  (fall[L_SLD]),
        .pin_m   (par_m),
        .pin_n   (par_n),
        .sr_word (sr_word),
        .m_o     (cfg_m),
        .n_o     (cfg_n),
        .t_o     (cfg_t),
        .upd_o   (cfg_update)
    );

    for (genvar r = 0; r < RATIO_W; r++) begin : g_ratio
        assign div_ratio_oh[r] = (cfg_n == N_W'(r));
    end

    // R8: exactly one ratio selected
    a_r8_ratio_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div_ratio_oh) == 1);
    // R9: update pulse never lasts two cycles
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

endmodule

// File: tb/synth_cfg_reg_tb_top.sv
module synth_cfg_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_strobe = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_strobe = 1'b0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic [3:0] div_ratio_oh;
    logic       cfg_update;

    int n_run = 0;
    int n_fail = 0;
    int upd_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    synth_cfg_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_strobe   (par_strobe),
        .par_m        (par_m),
        .par_n        (par_n),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .ser_strobe   (ser_strobe),
        .cfg_m        (cfg_m),
        .cfg_n        (cfg_n),
        .cfg_t        (cfg_t),
        .div_ratio_oh (div_ratio_oh),
        .cfg_update   (cfg_update)
    );

    always @(negedge clk) if (cfg_update) upd_cnt++;

    // {word[13:0], expected ratio[3:0]}; word = {T, N, M}
    localparam logic [17:0] VEC [0:5] = '{
        {3'd5, 2'd1, 9'h123, 4'b0010},
        {3'd2, 2'd3, 9'h0FF, 4'b1000},
        {3'd7, 2'd2, 9'h1AA, 4'b0100},
        {3'd0, 2'd0, 9'h055, 4'b0001},
        {3'd3, 2'd3, 9'h1FE, 4'b1000},
        {3'd6, 2'd1, 9'h001, 4'b0010}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ser_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) begin
            ser_data = w[i];
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
            cyc(4);
        end
    endtask

    task automatic ser_commit();
        ser_strobe = 1'b1;
        cyc(4);
        ser_strobe = 1'b0;
        cyc(5);
    endtask

    task automatic par_load(input logic [8:0] m, input logic [1:0] n);
        par_m = m;
        par_n = n;
        par_strobe = 1'b0;
        cyc(4);
        par_strobe = 1'b1;
        cyc(5);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        cyc(200000 - 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        logic [2:0] t_keep;
        cyc(3);
        // R1 during reset
        chk(cfg_m == 9'h1FF, "R1", "m in reset", cfg_m, 9'h1FF);
        chk(cfg_n == 2'd0 && cfg_t == 3'd0, "R1", "n,t in reset", {cfg_n, cfg_t}, 0);
        chk(div_ratio_oh == 4'b0001, "R1", "ratio in reset", div_ratio_oh, 4'b0001);
        rst_n = 1'b1;
        cyc(2);
        chk(cfg_m == 9'h1FF && cfg_update == 1'b0, "R1", "after reset",
            {cfg_update, cfg_m}, 9'h1FF);

        // R9: equal parallel values give no pulse
        upd_cnt = 0;
        par_load(9'h1FF, 2'd0);
        chk(upd_cnt == 0, "R9", "pulse on equal load", upd_cnt, 0);

        // R4: commit with no shifts writes zero
        upd_cnt = 0;
        ser_commit();
        chk({cfg_t, cfg_n, cfg_m} == 14'd0, "R4", "empty commit", {cfg_t, cfg_n, cfg_m}, 0);
        chk(upd_cnt == 1, "R9", "pulse count", upd_cnt, 1);

        // R3, R8: table walk
        foreach (VEC[k]) begin
            logic [13:0] w;
            w = VEC[k][17:4];
            upd_cnt = 0;
            ser_word(w);
            chk(cfg_m == 9'h000 || k != 0, "R3", "no change before commit", cfg_m, 0);
            ser_commit();
            chk(cfg_t == w[13:11], "R3", "t field", cfg_t, w[13:11]);
            chk(cfg_n == w[10:9], "R3", "n field", cfg_n, w[10:9]);
            chk(cfg_m == w[8:0], "R3", "m field", cfg_m, w[8:0]);
            chk(div_ratio_oh == VEC[k][3:0], "R8", "ratio", div_ratio_oh, VEC[k][3:0]);
            chk(upd_cnt == 1, "R9", "one pulse per change", upd_cnt, 1);
        end

        // R2, R7: parallel load keeps T (last T = 6)
        t_keep = cfg_t;
        par_load(9'h0A5, 2'd2);
        chk(cfg_m == 9'h0A5 && cfg_n == 2'd2, "R2", "parallel capture",
            {cfg_n, cfg_m}, {2'd2, 9'h0A5});
        chk(cfg_t == t_keep, "R7", "t after parallel", cfg_t, t_keep);
        chk(div_ratio_oh == 4'b0100, "R8", "ratio after parallel", div_ratio_oh, 4'b0100);

        // R5: serial commit while parallel strobe low
        par_m = 9'h0A5;
        par_n = 2'd2;
        par_strobe = 1'b0;
        cyc(5);
        ser_word({3'd1, 2'd3, 9'h133});
        upd_cnt = 0;
        ser_commit();
        chk(cfg_m == 9'h0A5 && cfg_n == 2'd2 && cfg_t == t_keep, "R5", "blocked commit",
            {cfg_t, cfg_n, cfg_m}, {t_keep, 2'd2, 9'h0A5});
        chk(upd_cnt == 0, "R5", "no pulse when blocked", upd_cnt, 0);

        // R6: coincident parallel rise and serial fall
        par_m = 9'h077;
        par_n = 2'd1;
        ser_strobe = 1'b1;
        cyc(4);
        par_strobe = 1'b1;
        ser_strobe = 1'b0;
        cyc(5);
        chk(cfg_m == 9'h077 && cfg_n == 2'd1, "R6", "parallel wins",
            {cfg_n, cfg_m}, {2'd1, 9'h077});
        chk(cfg_t == t_keep, "R6", "t kept", cfg_t, t_keep);

        // R10: latency of three edges, R9 pulse width
        par_strobe = 1'b0;
        cyc(4);
        par_m = 9'h10F;
        par_n = 2'd3;
        par_strobe = 1'b1;
        cyc(2);
        chk(cfg_m == 9'h077 && cfg_update == 1'b0, "R10", "old after two edges",
            {cfg_update, cfg_m}, 9'h077);
        cyc(1);
        chk(cfg_m == 9'h10F && cfg_n == 2'd3, "R10", "new after three edges",
            {cfg_n, cfg_m}, {2'd3, 9'h10F});
        chk(cfg_update == 1'b1, "R9", "pulse with new value", cfg_update, 1);
        cyc(1);
        chk(cfg_update == 1'b0, "R9", "pulse one cycle", cfg_update, 0);

        // R1: reset again restores defaults
        rst_n = 1'b0;
        cyc(2);
        chk({cfg_t, cfg_n, cfg_m} == {3'd0, 2'd0, 9'h1FF}, "R1", "re-reset",
            {cfg_t, cfg_n, cfg_m}, {3'd0, 2'd0, 9'h1FF});

        summary();
    end

endmodule